// File: doc/BRIEF.md
# Four-Channel Programmable Delay Generator

This block produces three timed outputs and one internal timing flag from a single start event. When a trigger arrives and the block is idle, it captures four 44-bit delay words. It then waits a fixed insertion latency and runs four independent down-counters. The channels are a timing channel T, two signal channels A and B, and an auxiliary channel. The auxiliary channel drives no pin; its only product is a one-cycle expiry pulse, intended for an interrupt controller.

The block has two output modes. In edge mode, each of T, A and B turns active on the clock edge where its own count runs out. All three return to idle together, one cycle after the last of the four channels has expired. In gate mode, A and B cooperate to shape a single pulse on the A output: A starts the pulse and B ends it. The B output stays idle in this mode. If the B delay is not greater than the A delay, no pulse is produced and an error flag is raised. Each output has its own polarity select.

Top module: `delay_gen_top`

## Requirements
- R1: A trigger (`trig_i` high at a rising clock edge) is accepted only while `busy_o` is low. Acceptance captures all four delays, the mode and the error condition, and `busy_o` is high from that edge until the edge LAT+max(delays)+1 cycles later (LAT defaults to 3).
- R2: Channel c expires on the edge LAT+D_c cycles after the accept edge. Its bit of `done_o` is high for exactly one cycle after that edge. Bit order is 0=T, 1=A, 2=B, 3=auxiliary.
- R3: A delay of zero expires exactly LAT cycles after the accept edge.
- R4: In edge mode (`gate_mode_i`=0), the T, A and B outputs each become active on their own expiry edge and stay active until release.
- R5: On the edge where `busy_o` falls, all three outputs return to idle together.
- R6: In gate mode (`gate_mode_i`=1), the A output is active from the A expiry edge up to the B expiry edge, and the B output stays idle throughout. The T output behaves as in edge mode.
- R7: In gate mode with D_B <= D_A, the A output never becomes active and `gate_err_o` is high. `gate_err_o` is set or cleared only at an accepted trigger.
- R8: Each output pin equals its active state XOR its polarity bit. `pol_i` bit 0 is T, bit 1 is A and bit 2 is B.
- R9: A trigger that arrives while `busy_o` is high is ignored. The running sequence and its captured delays are unaffected.
- R10: The auxiliary channel shows up only on `done_o[3]` and in the release time; it changes no output pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start request |
| gate_mode_i | input | 1 | 0 = edge mode, 1 = gate mode |
| pol_i | input | 3 | Output polarity, bit0 T, bit1 A, bit2 B |
| dly_t_i | input | 44 | Delay of channel T in clock ticks |
| dly_a_i | input | 44 | Delay of channel A |
| dly_b_i | input | 44 | Delay of channel B |
| dly_x_i | input | 44 | Delay of auxiliary channel |
| out_t_o | output | 1 | Timing output T |
| out_a_o | output | 1 | Output A (gate pulse in gate mode) |
| out_b_o | output | 1 | Output B |
| done_o | output | 4 | Per-channel one-cycle expiry pulses |
| busy_o | output | 1 | Sequence in progress |
| gate_err_o | output | 1 | Gate delays inverted or equal |

## Verification
The first edge-mode run uses distinct delays, so each expiry time is separate and a channel mapped to the wrong counter shows up. An all-zero run checks that the insertion latency alone sets the timing. Gate-mode runs with B after A, B equal to A and B before A separate a correct pulse from a missing error flag or a reversed pulse. A trigger held high through a whole run, together with delays changed mid-run, separates a correct ignore from a re-capture. A run with the auxiliary delay longest and inverted polarities confirms that release follows the auxiliary channel while the pins stay inverted and otherwise untouched.

// File: rtl/dg_pkg.sv
package dg_pkg;
    localparam int CH_T = 0;
    localparam int CH_A = 1;
    localparam int CH_B = 2;
    localparam int CH_X = 3;
    localparam int NUM_CH = 4;

    typedef enum logic {
        MODE_EDGE = 1'b0,
        MODE_GATE = 1'b1
    } out_mode_e;
endpackage

// File: rtl/dg_launch.sv
module dg_launch #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic launch_o
);
    logic [DEPTH-1:0] sr_d, sr_q;

    generate
        if (DEPTH == 1) begin : g_one
            always_comb sr_d = start_i;
        end else begin : g_many
            always_comb sr_d = {sr_q[DEPTH-2:0], start_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign launch_o = sr_q[DEPTH-1];
endmodule

// File: rtl/dg_chan.sv
module dg_chan #(
    parameter int W = 44
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch_i,
    input  logic [W-1:0] dly_i,
    output logic         expire_o
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] cnt;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (launch_i) begin
            c_d.pend = 1'b1;
            c_d.cnt  = dly_i;
        end else if (c_q.pend) begin
            if (c_q.cnt == '0) c_d.pend = 1'b0;
            else               c_d.cnt  = c_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign expire_o = c_q.pend && (c_q.cnt == '0);
endmodule

// File: rtl/delay_gen_top.sv
module delay_gen_top
    import dg_pkg::*;
#(
    parameter int W   = 44,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig_i,
    input  logic         gate_mode_i,
    input  logic [2:0]   pol_i,
    input  logic [W-1:0] dly_t_i,
    input  logic [W-1:0] dly_a_i,
    input  logic [W-1:0] dly_b_i,
    input  logic [W-1:0] dly_x_i,
    output logic         out_t_o,
    output logic         out_a_o,
    output logic         out_b_o,
    output logic [3:0]   done_o,
    output logic         busy_o,
    output logic         gate_err_o
);
    localparam int PIPE = (LAT > 1) ? LAT - 1 : 1;

    typedef struct packed {
        logic                        busy;
        out_mode_e                   mode;
        logic                        err;
        logic [NUM_CH-1:0][W-1:0]    dly;
        logic [NUM_CH-1:0]           exp;
        logic [NUM_CH-1:0]           done;
        logic [2:0]                  act;
    } state_t;

    state_t            state_d, state_q;
    logic              accept;
    logic              launch;
    logic [NUM_CH-1:0] expire;

    assign accept = trig_i && !state_q.busy;

    dg_launch #(.DEPTH(PIPE)) u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .launch_o (launch)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            dg_chan #(.W(W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .launch_i (launch),
                .dly_i    (state_q.dly[c]),
                .expire_o (expire[c])
            );
        end
    endgenerate

    always_comb begin
        state_d      = state_q;
        state_d.done = expire;
        if (accept) begin
            state_d.busy        = 1'b1;
            state_d.mode        = out_mode_e'(gate_mode_i);
            state_d.err         = gate_mode_i && (dly_b_i <= dly_a_i);
            state_d.dly[CH_T]   = dly_t_i;
            state_d.dly[CH_A]   = dly_a_i;
            state_d.dly[CH_B]   = dly_b_i;
            state_d.dly[CH_X]   = dly_x_i;
            state_d.exp         = '0;
            state_d.act         = '0;
        end else if (state_q.busy) begin
            if (&state_q.exp) begin
                state_d.busy = 1'b0;
                state_d.exp  = '0;
                state_d.act  = '0;
            end else begin
                state_d.exp = state_q.exp | expire;
                if (expire[CH_T]) state_d.act[CH_T] = 1'b1;
                if (state_q.mode == MODE_EDGE) begin
                    if (expire[CH_A]) state_d.act[CH_A] = 1'b1;
                    if (expire[CH_B]) state_d.act[CH_B] = 1'b1;
                end else begin
                    if (expire[CH_A] && !state_q.err) state_d.act[CH_A] = 1'b1;
                    if (expire[CH_B])                 state_d.act[CH_A] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_t_o    = state_q.act[CH_T] ^ pol_i[0];
    assign out_a_o    = state_q.act[CH_A] ^ pol_i[1];
    assign out_b_o    = state_q.act[CH_B] ^ pol_i[2];
    assign done_o     = state_q.done;
    assign busy_o     = state_q.busy;
    assign gate_err_o = state_q.err;
endmodule

// File: rtl/dg_checker.sv
module dg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic [2:0] pol_i,
    input logic       out_t_o,
    input logic       out_a_o,
    input logic       out_b_o,
    input logic [3:0] done_o,
    input logic       busy_o,
    input logic       gate_err_o,
    input logic       mode_q
);
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != 4'b0) |=> ((done_o & $past(done_o)) == 4'b0)); // R2

    AST_DONE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != 4'b0) |-> busy_o); // R2

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (out_t_o == pol_i[0] && out_a_o == pol_i[1] && out_b_o == pol_i[2])); // R5

    AST_GATE_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q) |-> (out_b_o == pol_i[2])); // R6

    AST_GATE_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q && gate_err_o) |-> (out_a_o == pol_i[1])); // R7

    AST_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> ($stable(mode_q) && $stable(gate_err_o))); // R9
endmodule

bind delay_gen_top dg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .pol_i      (pol_i),
    .out_t_o    (out_t_o),
    .out_a_o    (out_a_o),
    .out_b_o    (out_b_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .gate_err_o (gate_err_o),
    .mode_q     (state_q.mode)
);

// File: tb/delay_gen_top_test.sv
module delay_gen_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 44;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig_i = 1'b0;
    logic         gate_mode_i = 1'b0;
    logic [2:0]   pol_i = 3'b000;
    logic [W-1:0] dly_t_i = '0, dly_a_i = '0, dly_b_i = '0, dly_x_i = '0;
    logic         out_t_o, out_a_o, out_b_o, busy_o, gate_err_o;
    logic [3:0]   done_o;

    int checks = 0;
    int fails  = 0;
    string scen = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    delay_gen_top #(.W(W), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .gate_mode_i(gate_mode_i),
        .pol_i(pol_i), .dly_t_i(dly_t_i), .dly_a_i(dly_a_i), .dly_b_i(dly_b_i),
        .dly_x_i(dly_x_i), .out_t_o(out_t_o), .out_a_o(out_a_o), .out_b_o(out_b_o),
        .done_o(done_o), .busy_o(busy_o), .gate_err_o(gate_err_o)
    );

    // behavioural reference: times of events counted in edges
    longint edge_n = 0;
    longint t0 = 0;
    longint rel = 0;
    longint md[4];
    bit m_busy = 0, m_gate = 0, m_err = 0, m_valid = 0;

    always @(posedge clk) begin
        edge_n++;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_valid = 0;
        end else if (!m_busy && trig_i) begin
            longint mx;
            m_busy = 1; m_valid = 1; t0 = edge_n;
            md[0] = longint'(dly_t_i); md[1] = longint'(dly_a_i);
            md[2] = longint'(dly_b_i); md[3] = longint'(dly_x_i);
            m_gate = gate_mode_i;
            m_err  = gate_mode_i && (md[2] <= md[1]);
            mx = md[0];
            foreach (md[i]) if (md[i] > mx) mx = md[i];
            rel = t0 + LAT + mx + 1;
        end else if (m_busy && edge_n == rel) begin
            m_busy = 0;
        end
    end

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %b expected %b at edge %0d",
                     req, scen, what, act, exp, edge_n);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            longint x[4];
            bit a_t, a_a, a_b;
            foreach (x[i]) x[i] = t0 + LAT + md[i];
            for (int c = 0; c < 4; c++)
                chk("R2", done_o[c], m_valid && edge_n == x[c], $sformatf("done[%0d]", c));
            chk("R1", busy_o, m_busy, "busy");
            chk("R7", gate_err_o, m_err, "gate_err");
            a_t = m_busy && edge_n >= x[0];
            if (!m_gate) begin
                a_a = m_busy && edge_n >= x[1];
                a_b = m_busy && edge_n >= x[2];
            end else begin
                a_a = m_busy && !m_err && edge_n >= x[1] && edge_n < x[2];
                a_b = 1'b0;
            end
            chk("R4", out_t_o, a_t ^ pol_i[0], "out_t");
            chk(m_gate ? "R6" : "R4", out_a_o, a_a ^ pol_i[1], "out_a");
            chk(m_gate ? "R6" : "R4", out_b_o, a_b ^ pol_i[2], "out_b");
        end
    end

    task automatic run(bit g, logic [2:0] p, longint dt, longint da, longint db, longint dx);
        @(posedge clk); #1;
        gate_mode_i = g; pol_i = p;
        dly_t_i = W'(dt); dly_a_i = W'(da); dly_b_i = W'(db); dly_x_i = W'(dx);
        trig_i = 1'b1;
        @(posedge clk); #1;
        trig_i = 1'b0;
        while (m_busy) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (%s)", scen);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state: R1 idle, R8 pins at polarity
        scen = "R1 reset";
        chk("R1", busy_o, 1'b0, "busy after reset");
        chk("R8", out_a_o, 1'b0, "out_a after reset");

        scen = "R4 edge distinct";
        run(0, 3'b000, 4, 7, 2, 10);

        scen = "R9 held trigger";
        @(posedge clk); #1;
        gate_mode_i = 0; pol_i = 3'b000;
        dly_t_i = 5; dly_a_i = 2; dly_b_i = 6; dly_x_i = 1;
        trig_i = 1'b1;
        @(posedge clk); #1;
        dly_t_i = 1; dly_a_i = 1; dly_b_i = 1; dly_x_i = 1; gate_mode_i = 1;
        while (m_busy) @(posedge clk);
        @(posedge clk); #1;
        trig_i = 1'b0;
        while (m_busy) @(posedge clk);
        #1;

        scen = "R3 zero delays";
        run(0, 3'b000, 0, 0, 0, 0);

        scen = "R6 R8 gate pulse";
        run(1, 3'b010, 1, 3, 8, 2);

        scen = "R7 gate equal";
        run(1, 3'b000, 2, 5, 5, 1);
        @(negedge clk);
        chk("R7", gate_err_o, 1'b1, "error held after run");

        scen = "R7 gate reversed";
        run(1, 3'b110, 0, 9, 4, 3);

        scen = "R10 R5 aux longest";
        run(0, 3'b101, 3, 6, 1, 20);
        @(negedge clk);
        chk("R5", out_t_o, 1'b1, "out_t idle after release");
        chk("R10", out_b_o, 1'b1, "out_b idle after release");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule